// File: doc/BRIEF.md
# Accumulator Register-Reference Unit

This unit holds a 16-bit accumulator and a separate one-bit carry register. It carries out the single-word register-reference operations of a small accumulator processor. Each operation is chosen by one bit of a 12-bit one-hot field. The operations are clear, complement, rotate through carry, increment, three skip tests and a halt request. The sequencer and the I/O path can also update the accumulator through an encoded update port: AND, add, load, input byte and increment. Skip and halt are raised as combinational requests in the execute cycle. The sequencer uses a skip request to step the program counter one extra word, and uses a halt request to clear its run latch.

Memory access and instruction fetch belong to the surrounding processor. The unit only sees the operand word or input byte on `upd_data_i`.

Top module: `acc_regref_unit`

## Requirements
- R1: While `rst_ni` is low, the accumulator and the carry read 0. The reset is asynchronous.
- R2: With `rr_valid_i` high, field bit 11 clears the accumulator, bit 10 clears the carry, bit 9 inverts the accumulator and bit 8 inverts the carry. Each takes effect at the next rising clock edge.
- R3: Bit 7 rotates the 17-bit ring {carry, acc} right: the old carry enters acc[15] and acc[0] enters the carry. Bit 6 rotates the ring left: the old carry enters acc[0] and acc[15] enters the carry.
- R4: Bit 5 adds one to the accumulator, wrapping from 0xFFFF to 0x0000. The carry is left unchanged.
- R5: Bit 4 raises `skip_o` when acc[15] is 0, so zero counts as positive. Bit 3 raises `skip_o` when acc[15] is 1.
- R6: Bit 2 raises `skip_o` when the accumulator is 0x0000. Bit 1 raises `skip_o` when the carry is 0.
- R7: Bit 0 raises `halt_o` in the same cycle. `halt_o` is never high without `rr_valid_i` and bit 0.
- R8: Skip tests and halt leave the accumulator and the carry unchanged. `skip_o` and `halt_o` are low whenever `rr_valid_i` is low.
- R9: When several field bits are set, only the lowest-numbered set bit acts. An all-zero field changes nothing.
- R10: With `rr_valid_i` low, `upd_op_i` = 1 ANDs `upd_data_i` into the accumulator. A value of 3 loads it. A value of 4 replaces acc[7:0] with `upd_data_i[7:0]` and keeps acc[15:8]. A value of 0 holds the accumulator. None of these changes the carry.
- R11: `upd_op_i` = 2 adds `upd_data_i` to the accumulator and sets the carry to the carry-out. `upd_op_i` = 5 increments the accumulator with wrap and leaves the carry unchanged.
- R12: While `rr_valid_i` is high, `upd_op_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rr_valid_i | input | 1 | Execute a register-reference operation this cycle |
| rr_field_i | input | 12 | One-hot operation field |
| upd_op_i | input | 3 | Update operation code from the sequencer or I/O path |
| upd_data_i | input | 16 | Operand word; input byte in bits 7:0 |
| acc_o | output | 16 | Accumulator |
| carry_o | output | 1 | Carry register |
| skip_o | output | 1 | Skip request (combinational) |
| halt_o | output | 1 | Halt request (combinational) |

## Verification
Several behaviours are checked on every cycle by properties. These are the reset value, clear, rotate-right ring movement, increment keeping the carry, add carry-out, the rule that skip and halt appear only with a valid operation, and the rule that a zero field holds state. Other behaviours can only be shown by the bench's scenarios. These are the sign and zero test outcomes at their edge values (0x0000, 0x7FFF, 0x8000), the priority among several set field bits, the byte merge on input, and the blocking of a concurrent update by a register-reference operation. The bench sets up these cases by preloading the accumulator and the carry through the unit's own ports.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned FIELD_W = 12;
  localparam int unsigned BYTE_W  = 8;

  // value = field bit index + 1
  typedef enum logic [3:0] {
    RR_NONE = 4'd0,
    RR_HLT  = 4'd1,
    RR_SZE  = 4'd2,
    RR_SZA  = 4'd3,
    RR_SNA  = 4'd4,
    RR_SPA  = 4'd5,
    RR_INC  = 4'd6,
    RR_CIL  = 4'd7,
    RR_CIR  = 4'd8,
    RR_CME  = 4'd9,
    RR_CMA  = 4'd10,
    RR_CLE  = 4'd11,
    RR_CLA  = 4'd12
  } rr_op_e;

  typedef enum logic [2:0] {
    UPD_NONE   = 3'd0,
    UPD_AND    = 3'd1,
    UPD_ADD    = 3'd2,
    UPD_LOAD   = 3'd3,
    UPD_INBYTE = 3'd4,
    UPD_INC    = 3'd5
  } upd_op_e;
endpackage

// File: rtl/acc_field_decode.sv
module acc_field_decode
  import acc_pkg::*;
#(
  parameter int unsigned FIELD_W = acc_pkg::FIELD_W
) (
  input  logic               valid_i,
  input  logic [FIELD_W-1:0] field_i,
  output rr_op_e             op_o
);
  logic [FIELD_W-1:0] lowest;
  logic [3:0]         idx;

  // isolate the lowest set bit
  assign lowest = field_i & (~field_i + FIELD_W'(1));

  always_comb begin
    idx = 4'd0;
    for (int i = 0; i < FIELD_W; i++) begin
      if (lowest[i]) idx = 4'(i + 1);
    end
  end

  assign op_o = valid_i ? rr_op_e'(idx) : RR_NONE;
endmodule

// File: rtl/acc_test_eval.sv
module acc_test_eval
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = acc_pkg::DATA_W
) (
  input  rr_op_e            op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              carry_i,
  output logic              skip_o,
  output logic              halt_o
);
  logic sign_bit;
  logic acc_zero;

  assign sign_bit = acc_i[DATA_W-1];
  assign acc_zero = (acc_i == '0);

  always_comb begin
    skip_o = 1'b0;
    unique case (op_i)
      RR_SPA:  skip_o = ~sign_bit;
      RR_SNA:  skip_o = sign_bit;
      RR_SZA:  skip_o = acc_zero;
      RR_SZE:  skip_o = ~carry_i;
      default: skip_o = 1'b0;
    endcase
  end

  assign halt_o = (op_i == RR_HLT);
endmodule

// File: rtl/acc_next_calc.sv
module acc_next_calc
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = acc_pkg::DATA_W,
  parameter int unsigned BYTE_W = acc_pkg::BYTE_W
) (
  input  rr_op_e            rr_op_i,
  input  upd_op_e           upd_op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              carry_o
);
  localparam int unsigned SUM_W = DATA_W + 1;

  logic [SUM_W-1:0]  sum;
  logic [DATA_W-1:0] acc_inc;

  assign sum     = {1'b0, acc_i} + {1'b0, data_i};
  assign acc_inc = acc_i + DATA_W'(1);

  always_comb begin
    acc_o   = acc_i;
    carry_o = carry_i;
    if (rr_op_i != RR_NONE) begin
      unique case (rr_op_i)
        RR_CLA: acc_o   = '0;
        RR_CLE: carry_o = 1'b0;
        RR_CMA: acc_o   = ~acc_i;
        RR_CME: carry_o = ~carry_i;
        RR_CIR: begin
          acc_o   = {carry_i, acc_i[DATA_W-1:1]};
          carry_o = acc_i[0];
        end
        RR_CIL: begin
          acc_o   = {acc_i[DATA_W-2:0], carry_i};
          carry_o = acc_i[DATA_W-1];
        end
        RR_INC:  acc_o = acc_inc;
        default: ;
      endcase
    end else begin
      unique case (upd_op_i)
        UPD_AND:  acc_o = acc_i & data_i;
        UPD_ADD: begin
          acc_o   = sum[DATA_W-1:0];
          carry_o = sum[DATA_W];
        end
        UPD_LOAD:   acc_o = data_i;
        UPD_INBYTE: acc_o = {acc_i[DATA_W-1:BYTE_W], data_i[BYTE_W-1:0]};
        UPD_INC:    acc_o = acc_inc;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_regref_unit.sv
module acc_regref_unit
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W  = acc_pkg::DATA_W,
  parameter int unsigned FIELD_W = acc_pkg::FIELD_W,
  parameter int unsigned BYTE_W  = acc_pkg::BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rr_valid_i,
  input  logic [FIELD_W-1:0] rr_field_i,
  input  logic [2:0]         upd_op_i,
  input  logic [DATA_W-1:0]  upd_data_i,
  output logic [DATA_W-1:0]  acc_o,
  output logic               carry_o,
  output logic               skip_o,
  output logic               halt_o
);
  rr_op_e            rr_op;
  upd_op_e           upd_eff;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              carry_q, carry_d;

  acc_field_decode #(.FIELD_W(FIELD_W)) u_decode (
    .valid_i (rr_valid_i),
    .field_i (rr_field_i),
    .op_o    (rr_op)
  );

  // a register-reference cycle owns the accumulator
  assign upd_eff = rr_valid_i ? UPD_NONE : upd_op_e'(upd_op_i);

  acc_next_calc #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_calc (
    .rr_op_i  (rr_op),
    .upd_op_i (upd_eff),
    .data_i   (upd_data_i),
    .acc_i    (acc_q),
    .carry_i  (carry_q),
    .acc_o    (acc_d),
    .carry_o  (carry_d)
  );

  acc_test_eval #(.DATA_W(DATA_W)) u_eval (
    .op_i    (rr_op),
    .acc_i   (acc_q),
    .carry_i (carry_q),
    .skip_o  (skip_o),
    .halt_o  (halt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      carry_q <= carry_d;
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/acc_regref_unit_chk.sv
module acc_regref_unit_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned FIELD_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rr_valid_i,
  input logic [FIELD_W-1:0] rr_field_i,
  input logic [2:0]         upd_op_i,
  input logic [DATA_W-1:0]  upd_data_i,
  input logic [DATA_W-1:0]  acc_o,
  input logic               carry_o,
  input logic               skip_o,
  input logic               halt_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (acc_o == '0 && !carry_o));

  // R2
  cla_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_valid_i && rr_field_i == FIELD_W'(12'h800)) |=> (acc_o == '0));

  // R3
  cir_ring_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_valid_i && rr_field_i == FIELD_W'(12'h080)) |=>
      (acc_o == {$past(carry_o), $past(acc_o[DATA_W-1:1])} && carry_o == $past(acc_o[0])));

  // R4
  inc_keep_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_valid_i && rr_field_i == FIELD_W'(12'h020)) |=>
      (carry_o == $past(carry_o) && acc_o == $past(acc_o) + DATA_W'(1)));

  // R7
  halt_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (rr_valid_i && rr_field_i[0]));

  // R8
  skip_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> rr_valid_i);

  // R9
  zero_field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_valid_i && rr_field_i == '0) |=> ($stable(acc_o) && $stable(carry_o)));

  // R11
  add_carry_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rr_valid_i && upd_op_i == 3'd2) |=>
      ({carry_o, acc_o} == {1'b0, $past(acc_o)} + {1'b0, $past(upd_data_i)}));
endmodule

bind acc_regref_unit acc_regref_unit_chk #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rr_valid_i (rr_valid_i),
  .rr_field_i (rr_field_i),
  .upd_op_i   (upd_op_i),
  .upd_data_i (upd_data_i),
  .acc_o      (acc_o),
  .carry_o    (carry_o),
  .skip_o     (skip_o),
  .halt_o     (halt_o)
);

// File: tb/acc_regref_unit_bench.sv
module acc_regref_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rr_valid_i = 1'b0;
  logic [11:0] rr_field_i = '0;
  logic [2:0]  upd_op_i = '0;
  logic [15:0] upd_data_i = '0;
  logic [15:0] acc_o;
  logic        carry_o, skip_o, halt_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  acc_regref_unit u_acc_regref_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .rr_valid_i(rr_valid_i), .rr_field_i(rr_field_i),
    .upd_op_i(upd_op_i), .upd_data_i(upd_data_i), .acc_o(acc_o), .carry_o(carry_o),
    .skip_o(skip_o), .halt_o(halt_o)
  );

  // {pre_acc, pre_c, field, exp_acc, exp_c, exp_skip, exp_halt}
  localparam int NV = 22;
  localparam logic [47:0] VEC [NV] = '{
    {16'h1234, 1'b0, 12'h800, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h1234, 1'b1, 12'h400, 16'h1234, 1'b0, 1'b0, 1'b0},
    {16'h00FF, 1'b0, 12'h200, 16'hFF00, 1'b0, 1'b0, 1'b0},
    {16'h1234, 1'b0, 12'h100, 16'h1234, 1'b1, 1'b0, 1'b0},
    {16'h8001, 1'b0, 12'h080, 16'h4000, 1'b1, 1'b0, 1'b0},
    {16'h0002, 1'b1, 12'h080, 16'h8001, 1'b0, 1'b0, 1'b0},
    {16'h8001, 1'b0, 12'h040, 16'h0002, 1'b1, 1'b0, 1'b0},
    {16'h4000, 1'b1, 12'h040, 16'h8001, 1'b0, 1'b0, 1'b0},
    {16'hFFFF, 1'b1, 12'h020, 16'h0000, 1'b1, 1'b0, 1'b0},
    {16'h7FFF, 1'b0, 12'h020, 16'h8000, 1'b0, 1'b0, 1'b0},
    {16'h0000, 1'b0, 12'h010, 16'h0000, 1'b0, 1'b1, 1'b0},
    {16'h8000, 1'b0, 12'h010, 16'h8000, 1'b0, 1'b0, 1'b0},
    {16'h8000, 1'b0, 12'h008, 16'h8000, 1'b0, 1'b1, 1'b0},
    {16'h7FFF, 1'b0, 12'h008, 16'h7FFF, 1'b0, 1'b0, 1'b0},
    {16'h0000, 1'b1, 12'h004, 16'h0000, 1'b1, 1'b1, 1'b0},
    {16'h0001, 1'b0, 12'h004, 16'h0001, 1'b0, 1'b0, 1'b0},
    {16'h1111, 1'b0, 12'h002, 16'h1111, 1'b0, 1'b1, 1'b0},
    {16'h1111, 1'b1, 12'h002, 16'h1111, 1'b1, 1'b0, 1'b0},
    {16'h5555, 1'b1, 12'h001, 16'h5555, 1'b1, 1'b0, 1'b1},
    {16'h1234, 1'b0, 12'h820, 16'h1235, 1'b0, 1'b0, 1'b0},
    {16'h0000, 1'b0, 12'h204, 16'h0000, 1'b0, 1'b1, 1'b0},
    {16'h1234, 1'b1, 12'h000, 16'h1234, 1'b1, 1'b0, 1'b0}
  };

  function automatic string tag_of(input logic [11:0] f);
    case (f)
      12'h800, 12'h400, 12'h200, 12'h100: return "R2";
      12'h080, 12'h040: return "R3";
      12'h020:          return "R4";
      12'h010, 12'h008: return "R5";
      12'h004, 12'h002: return "R6";
      12'h001:          return "R7";
      default:          return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic upd(input logic [2:0] op, input logic [15:0] d);
    @(negedge clk_i);
    upd_op_i = op; upd_data_i = d;
    @(negedge clk_i);
    upd_op_i = 3'd0;
  endtask

  task automatic rr(input logic [11:0] f, output logic sk, output logic hl);
    @(negedge clk_i);
    rr_valid_i = 1'b1; rr_field_i = f;
    #1;
    sk = skip_o; hl = halt_o;
    @(negedge clk_i);
    rr_valid_i = 1'b0; rr_field_i = '0;
  endtask

  task automatic preload(input logic [15:0] a, input logic c);
    logic sk, hl;
    upd(3'd3, a);
    rr(12'h400, sk, hl);
    if (c) rr(12'h100, sk, hl);
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic sk, hl;
    #1;
    // R1 reset state
    check("R1", "acc in reset", 32'(acc_o), 32'h0);
    check("R1", "carry in reset", 32'(carry_o), 32'h0);
    #6 rst_ni = 1'b1;

    // R8 idle outputs
    @(negedge clk_i);
    check("R8", "idle skip", 32'(skip_o), 32'h0);
    check("R8", "idle halt", 32'(halt_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      preload(v[47:32], v[31]);
      rr(v[30:19], sk, hl);
      check(tag_of(v[30:19]), "acc", 32'(acc_o), 32'(v[18:3]));
      check(tag_of(v[30:19]), "carry", 32'(carry_o), 32'(v[2]));
      check(tag_of(v[30:19]), "skip", 32'(sk), 32'(v[1]));
      check(tag_of(v[30:19]), "halt", 32'(hl), 32'(v[0]));
      if (v[30:19] inside {12'h010, 12'h008, 12'h004, 12'h002, 12'h001})
        check("R8", "test op keeps acc", 32'(acc_o), 32'(v[47:32]));
    end

    // R10 update ops
    preload(16'hF0F0, 1'b1);
    check("R10", "load", 32'(acc_o), 32'hF0F0);
    upd(3'd1, 16'h3C3C);
    check("R10", "and", 32'(acc_o), 32'h3030);
    check("R10", "and keeps carry", 32'(carry_o), 32'h1);
    upd(3'd4, 16'hEEAB);
    check("R10", "input byte", 32'(acc_o), 32'h30AB);
    upd(3'd0, 16'hFFFF);
    check("R10", "no-op hold", 32'(acc_o), 32'h30AB);

    // R11 add and increment
    preload(16'hFFFF, 1'b0);
    upd(3'd2, 16'h0001);
    check("R11", "add wrap acc", 32'(acc_o), 32'h0000);
    check("R11", "add carry out", 32'(carry_o), 32'h1);
    upd(3'd2, 16'h0001);
    check("R11", "add no carry acc", 32'(acc_o), 32'h0001);
    check("R11", "add no carry", 32'(carry_o), 32'h0);
    preload(16'hFFFF, 1'b1);
    upd(3'd5, 16'h0000);
    check("R11", "upd inc wrap", 32'(acc_o), 32'h0000);
    check("R11", "upd inc carry", 32'(carry_o), 32'h1);

    // R12 register-reference blocks update
    preload(16'h0F0F, 1'b0);
    @(negedge clk_i);
    rr_valid_i = 1'b1; rr_field_i = 12'h100; upd_op_i = 3'd3; upd_data_i = 16'hAAAA;
    @(negedge clk_i);
    rr_valid_i = 1'b0; rr_field_i = '0; upd_op_i = 3'd0;
    check("R12", "acc untouched by update", 32'(acc_o), 32'h0F0F);
    check("R12", "rr op applied", 32'(carry_o), 32'h1);

    // R1 asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1;
    check("R1", "async reset acc", 32'(acc_o), 32'h0);
    check("R1", "async reset carry", 32'(carry_o), 32'h0);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule